// File: doc/BRIEF.md
# Channel Buffer Underflow Panic Controller

This block protects a video decoder from starving its elementary-stream channel buffer. The host programs a 24-bit low-water threshold and picks what the threshold is measured against: the count of buffered 64-bit items or the count of buffered whole pictures. The block compares the chosen live occupancy count against the threshold on every cycle. The result of that comparison takes effect only at the reconstruction boundary, which the decoder marks with a one-cycle strobe just before it starts rebuilding a picture.

When the sampled result says the buffer is running dry, the block holds the decoder in a panic slot. It gates off every channel byte request and tells the display to keep repeating the last field it showed. At each later reconstruction strobe the block samples the comparison again. The freeze lifts on its own once the occupancy is back at or above the threshold.

A host request to skip a frame does not break a panic. The request is kept pending and is released as a one-cycle skip command at the first boundary whose sample is clear.

Top module: `vbuf_panic_ctrl`

## Requirements
- R1: With mode select 2'b01, a reconstruction strobe samples panic as 1 exactly when the item count is strictly below the threshold.
- R2: With mode select 2'b10, a reconstruction strobe samples panic as 1 exactly when the picture count is strictly below the threshold.
- R3: With mode select 2'b00 or 2'b11, a strobe always samples panic as 0, whatever the counts and the threshold are.
- R4: The threshold is 24 bits wide and is written one byte at a time. Register address 0 holds bits 7:0, address 1 holds bits 15:8 and address 2 holds bits 23:16. A write to address 3 changes nothing.
- R5: `panic_o` takes the sampled value in the cycle after a strobe. It holds that value in every cycle that follows a cycle without a strobe.
- R6: `chan_req_en` equals `fetch_want` when `panic_o` is 0. It is 0 in every cycle in which `panic_o` is 1.
- R7: `freeze_o` is 1 in exactly the cycles in which the sampled panic is active, so the display repeats its current frame.
- R8: A skip request (a `skip_req` pulse) is remembered. It produces a one-cycle `skip_go` pulse in the cycle after the first strobe that samples panic as 0, and it produces no pulse while panic is being sampled.
- R9: Panic and freeze are released at the first strobe after the occupancy has risen to a value equal to or above the threshold.
- R10: After reset, `panic_o`, `freeze_o` and `skip_go` are 0 and the threshold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 01 compares items, 10 compares pictures, 00 or 11 turns the feature off |
| thr_we | input | 1 | Threshold byte write enable |
| thr_addr | input | 2 | Threshold byte address, where 0 is the least significant byte |
| thr_wdata | input | 8 | Threshold byte write data |
| item_count | input | ITEM_W | Live count of buffered 64-bit items |
| pic_count | input | PIC_W | Live count of buffered pictures |
| recon_strobe | input | 1 | Pulse marking the point just before picture reconstruction starts |
| skip_req | input | 1 | Host skip-frame request pulse |
| fetch_want | input | 1 | The decoder wants channel bytes |
| panic_o | output | 1 | Sampled panic flag |
| chan_req_en | output | 1 | Gated channel byte request |
| freeze_o | output | 1 | Freeze the display and repeat the current frame |
| skip_go | output | 1 | One-cycle command to carry out a pending skip |

## Verification
The bench changes the occupancy counts between strobes and expects `panic_o` to stay put until the next strobe. A design that compared continuously would let panic flicker in mid-picture. The equality case, where the count exactly matches the threshold, catches an off-by-one compare that would hold the freeze for one boundary too long. A write to the unused fourth address, and a threshold placed above 255, catch byte-lane and endianness mix-ups, which would move the trip point. A skip request issued during panic must survive one or more panicking strobes and fire only after the refill. A design that dropped the request would never skip, and one that let it through early would skip a frame while the display was still frozen.

// File: rtl/vbp_pkg.sv
package vbp_pkg;
  typedef enum logic [1:0] {
    CMP_OFF_A = 2'b00,
    CMP_ITEMS = 2'b01,
    CMP_PICS  = 2'b10,
    CMP_OFF_B = 2'b11
  } cmp_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/vbp_thr_regs.sv
module vbp_thr_regs
  import vbp_pkg::*;
#(
  parameter int unsigned NBYTES = 3,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned THR_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [THR_W-1:0]  thr
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q, byte_d;
    logic              byte_en;

    always_comb begin
      byte_en = we && (addr == ADDR_W'(b));
      byte_d  = byte_en ? wdata : byte_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign thr[b*BYTE_W +: BYTE_W] = byte_q;
  end

  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(thr)); // R4
endmodule

// File: rtl/vbp_compare.sv
module vbp_compare
  import vbp_pkg::*;
#(
  parameter int unsigned THR_W  = 24,
  parameter int unsigned ITEM_W = 20,
  parameter int unsigned PIC_W  = 8
) (
  input  logic [1:0]        mode_sel,
  input  logic [THR_W-1:0]  thr,
  input  logic [ITEM_W-1:0] item_count,
  input  logic [PIC_W-1:0]  pic_count,
  output logic              raw_panic
);
  logic [THR_W-1:0] item_ext, pic_ext;

  always_comb begin
    item_ext = THR_W'(item_count);
    pic_ext  = THR_W'(pic_count);
    unique case (cmp_mode_e'(mode_sel))
      CMP_ITEMS: raw_panic = (item_ext < thr);
      CMP_PICS:  raw_panic = (pic_ext < thr);
      default:   raw_panic = 1'b0;
    endcase
  end
endmodule

// File: rtl/vbp_sampler.sv
module vbp_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic recon_strobe,
  input  logic raw_panic,
  input  logic skip_req,
  output logic panic_q,
  output logic skip_go_q
);
  logic panic_d, pend_q, pend_d, go_d, clear_slot;

  always_comb begin
    clear_slot = recon_strobe && !raw_panic;
    panic_d    = recon_strobe ? raw_panic : panic_q;
    go_d       = clear_slot && (pend_q || skip_req);
    pend_d     = (pend_q || skip_req) && !clear_slot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      panic_q   <= 1'b0;
      pend_q    <= 1'b0;
      skip_go_q <= 1'b0;
    end else begin
      panic_q   <= panic_d;
      pend_q    <= pend_d;
      skip_go_q <= go_d;
    end
  end

  AST_PANIC_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !recon_strobe |=> $stable(panic_q)); // R5
  AST_SKIP_NOT_IN_PANIC: assert property (@(posedge clk) disable iff (!rst_n)
    skip_go_q |-> !panic_q); // R8
  AST_SKIP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    skip_go_q |=> !skip_go_q); // R8
endmodule

// File: rtl/vbuf_panic_ctrl.sv
module vbuf_panic_ctrl
  import vbp_pkg::*;
#(
  parameter int unsigned THR_BYTES = 3,
  parameter int unsigned ITEM_W    = 20,
  parameter int unsigned PIC_W     = 8,
  localparam int unsigned THR_W    = THR_BYTES * BYTE_W,
  localparam int unsigned ADDR_W   = $clog2(THR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              thr_we,
  input  logic [ADDR_W-1:0] thr_addr,
  input  logic [7:0]        thr_wdata,
  input  logic [ITEM_W-1:0] item_count,
  input  logic [PIC_W-1:0]  pic_count,
  input  logic              recon_strobe,
  input  logic              skip_req,
  input  logic              fetch_want,
  output logic              panic_o,
  output logic              chan_req_en,
  output logic              freeze_o,
  output logic              skip_go
);
  logic [THR_W-1:0] thr;
  logic             raw_panic;
  logic             panic_q;

  vbp_thr_regs #(.NBYTES(THR_BYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(thr_we), .addr(thr_addr),
    .wdata(thr_wdata), .thr(thr)
  );

  vbp_compare #(.THR_W(THR_W), .ITEM_W(ITEM_W), .PIC_W(PIC_W)) u_cmp (
    .mode_sel(mode_sel), .thr(thr), .item_count(item_count),
    .pic_count(pic_count), .raw_panic(raw_panic)
  );

  vbp_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .recon_strobe(recon_strobe),
    .raw_panic(raw_panic), .skip_req(skip_req),
    .panic_q(panic_q), .skip_go_q(skip_go)
  );

  always_comb begin
    panic_o     = panic_q;
    freeze_o    = panic_q;
    chan_req_en = fetch_want && !panic_q;
  end

  AST_NO_REQ_IN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_req_en |-> !freeze_o); // R6
  AST_MODE_OFF_NO_PANIC: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_strobe && (mode_sel == 2'b00 || mode_sel == 2'b11)) |=> !panic_o); // R3
  AST_REFILL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (recon_strobe && mode_sel == 2'b01 && {4'b0, item_count} >= thr) |=> !freeze_o); // R9
endmodule

// File: tb/vbuf_panic_ctrl_tb.sv
module vbuf_panic_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        thr_we;
  logic [1:0]  thr_addr;
  logic [7:0]  thr_wdata;
  logic [19:0] item_count;
  logic [7:0]  pic_count;
  logic        recon_strobe, skip_req, fetch_want;
  logic        panic_o, chan_req_en, freeze_o, skip_go;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  int m_thr, m_panic, m_pend, m_go;

  always #(CLK_PERIOD/2) clk = ~clk;

  vbuf_panic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .thr_we(thr_we),
    .thr_addr(thr_addr), .thr_wdata(thr_wdata), .item_count(item_count),
    .pic_count(pic_count), .recon_strobe(recon_strobe), .skip_req(skip_req),
    .fetch_want(fetch_want), .panic_o(panic_o), .chan_req_en(chan_req_en),
    .freeze_o(freeze_o), .skip_go(skip_go)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_thr = 0; m_panic = 0; m_pend = 0; m_go = 0;
    end else begin
      int raw;
      int occ;
      occ = (mode_sel == 2'b01) ? int'(item_count) : int'(pic_count);
      raw = (mode_sel == 2'b01 || mode_sel == 2'b10) ? int'(occ < m_thr) : 0;
      m_go = (recon_strobe && !raw && (m_pend || skip_req)) ? 1 : 0;
      if (recon_strobe && !raw) m_pend = 0;
      else if (skip_req)        m_pend = 1;
      if (recon_strobe) m_panic = raw;
      if (thr_we && thr_addr != 2'd3) begin
        int sh;
        sh = 8 * int'(thr_addr);
        m_thr = (m_thr & ~(32'hFF << sh)) | (int'(thr_wdata) << sh);
      end
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, int'(panic_o), m_panic, "panic_o");
      chk("R7", int'(freeze_o), m_panic, "freeze_o");
      chk("R8", int'(skip_go), m_go, "skip_go");
      chk("R6", int'(chan_req_en), int'(fetch_want && !m_panic), "chan_req_en");
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    thr_we = 1'b1; thr_addr = a; thr_wdata = d; cyc();
    thr_we = 1'b0; cyc();
  endtask

  task automatic strobe();
    recon_strobe = 1'b1; cyc();
    recon_strobe = 1'b0; cyc();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; thr_we = 1'b0; thr_addr = 2'd0; thr_wdata = 8'd0;
    item_count = '0; pic_count = '0; recon_strobe = 1'b0; skip_req = 1'b0;
    fetch_want = 1'b1;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R10: reset state, threshold 0 -> no panic even in item mode with count 0
    chk("R10", int'(panic_o), 0, "panic after reset");
    chk("R10", int'(freeze_o), 0, "freeze after reset");
    chk("R10", int'(skip_go), 0, "skip_go after reset");
    mode_sel = 2'b01; strobe();
    chk("R10", int'(panic_o), 0, "zero threshold no panic");

    // R4: bytes, address 3 ignored; threshold = 0x10
    cur_req = "R4";
    wr(2'd0, 8'h10); wr(2'd3, 8'hFF);
    item_count = 20'h0F; strobe();
    chk("R1", int'(panic_o), 1, "items below threshold");
    cur_req = "R9";
    item_count = 20'h10; strobe();
    chk("R9", int'(panic_o), 0, "equal count releases");
    // R4: little-endian, threshold = 0x110
    cur_req = "R4";
    wr(2'd1, 8'h01);
    item_count = 20'h10F; strobe();
    chk("R4", int'(panic_o), 1, "0x10F below 0x110");
    item_count = 20'h110; strobe();
    chk("R4", int'(panic_o), 0, "0x110 not below 0x110");
    wr(2'd2, 8'h01); // threshold 0x010110
    item_count = 20'h1010F; strobe();
    chk("R4", int'(panic_o), 1, "upper byte lane");
    item_count = 20'h10110; strobe();

    // R5 and R6: counts drop without a strobe, panic must not move
    cur_req = "R5";
    item_count = 20'h0; fetch_want = 1'b1;
    repeat (4) cyc();
    chk("R5", int'(panic_o), 0, "no change without strobe");
    chk("R6", int'(chan_req_en), 1, "request passes when clear");
    strobe();
    chk("R6", int'(chan_req_en), 0, "request gated in panic");
    chk("R7", int'(freeze_o), 1, "freeze in panic");
    item_count = 20'hFFFFF; repeat (3) cyc();
    chk("R5", int'(panic_o), 1, "held until strobe");

    // R8: skip during panic stays pending
    cur_req = "R8";
    item_count = 20'h0; skip_req = 1'b1; cyc(); skip_req = 1'b0;
    strobe();
    chk("R8", int'(panic_o), 1, "still panicking");
    item_count = 20'hFFFFF;
    recon_strobe = 1'b1; cyc(); recon_strobe = 1'b0;
    chk("R8", int'(skip_go), 1, "skip fires after refill");
    cyc();
    chk("R8", int'(skip_go), 0, "skip is one cycle");
    strobe();
    chk("R8", int'(skip_go), 0, "skip consumed");

    // R2: picture mode with threshold 5
    cur_req = "R2";
    wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h05);
    mode_sel = 2'b10; item_count = 20'h0;
    pic_count = 8'd4; strobe();
    chk("R2", int'(panic_o), 1, "pics below threshold");
    pic_count = 8'd5; strobe();
    chk("R2", int'(panic_o), 0, "pics at threshold");

    // R3: disabled modes
    cur_req = "R3";
    pic_count = 8'd0;
    mode_sel = 2'b00; strobe();
    chk("R3", int'(panic_o), 0, "mode 00 off");
    mode_sel = 2'b11; strobe();
    chk("R3", int'(panic_o), 0, "mode 11 off");

    // R8: skip with no panic fires at next strobe
    cur_req = "R8";
    skip_req = 1'b1; cyc(); skip_req = 1'b0; cyc();
    chk("R8", int'(skip_go), 0, "no skip before boundary");
    recon_strobe = 1'b1; cyc(); recon_strobe = 1'b0;
    chk("R8", int'(skip_go), 1, "skip at boundary");
    repeat (3) cyc();
    finish_run();
  end
endmodule